// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block is a small programmable engine that drives a DRAM command bus during memory training and memory test. Software fills up to four slots through a write port. Each slot describes one run of a single command: which command, to which rank, how many times, how many clocks apart, and how long to wait before the next slot starts. Each slot also holds a start bank and address and rules for stepping them between issues. A write to the go register then starts the engine. It plays the active slots in order, optionally repeats the whole list several times, and needs no software help until it finishes.

On every issue cycle the engine drives a command code, bank, row/column address and rank, together with a read or write data-phase strobe taken from the slot's direction. A timer mode runs the same schedule with the command bus held quiet, so the engine can serve as a programmable delay. Software polls a status byte: one bit shows a run in progress, and one of two done bits shows how the last run ended.

Top module: `dts_seq`

## Requirements
- R1: After a synchronous active-low reset, `status` reads 0 and `cmd_valid`, `rd_phase` and `wr_phase` are low.
- R2: A config write selects the slot with `cfg_slot` and the word with `cfg_field`. Word 0 holds command [3:0], rank [5:4] and direction [7:6] (0 none, 1 read, 2 write). Word 1 holds the repeat count [15:0] and the gap [23:16]. Word 2 holds the post-wait [15:0], bank stepping [16], column stepping [17] and the wrap position [22:18]. Word 3 holds the start address [15:0] and the start bank [18:16]. A config write made while a run is busy is ignored.
- R3: A go write when idle starts a run. Its fields are the loop count [7:0], the number of active slots minus one [19:18] and the timer flag [22]. `status[0]` rises and slot 0 issues its first command in the cycle right after the accepting edge.
- R4: A go write made while a run is busy is ignored, and the run in progress carries on unchanged.
- R5: A slot issues its command as many times as its repeat count says, a count of 0 acting as 1. Consecutive issues start `gap` cycles apart, a gap of 0 acting as 1, which gives back-to-back issues.
- R6: After a slot's last issue, the next slot's first issue comes `post + 1` cycles later.
- R7: With bank stepping set, the bank rises by one after each issue within the slot and wraps from 7 to 0. Without it, the bank stays at the start bank.
- R8: With column stepping set, the address rises by 8 after each issue. Bits at or above the wrap position are cleared, and a wrap of 0 means no clearing. Every new slot entry and every new loop restarts from the slot's start address and start bank.
- R9: `rd_phase` is high on the issue cycles of a slot whose direction is read, and `wr_phase` on those of a slot whose direction is write. Neither is high on any other cycle.
- R10: The whole slot list is played `loops` times, a loop count of 0 acting as 1.
- R11: One cycle after the final post-wait of the last loop (or after the final issue when that post-wait is 0), `status[0]` falls. At the same time `status[4]` (normal run) or `status[6]` (timer run) rises. Both done bits clear when the next run is accepted.
- R12: In timer mode the schedule is the same, but `cmd_valid` and both strobes stay low for the whole run.
- R13: Command codes are NOP 0, MRS 1, ACT 2, RD 3, WR 4, PRE 5, ZQCS 6 and alternate NOP 7. The slot's code and rank appear unchanged on `cmd_code` and `cmd_rank` during its issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Slot config write strobe |
| cfg_slot | input | 2 | Slot selected for the config write |
| cfg_field | input | 2 | Word selected within the slot |
| cfg_wdata | input | 32 | Config write data |
| go_we | input | 1 | Go register write strobe |
| go_wdata | input | 32 | Loop count, slot count minus one and timer flag |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_code | output | 4 | Command code |
| cmd_bank | output | 3 | Bank |
| cmd_addr | output | 16 | Row or column address |
| cmd_rank | output | 2 | Rank |
| rd_phase | output | 1 | Read data phase strobe |
| wr_phase | output | 1 | Write data phase strobe |
| status | output | 8 | Bit 0 busy, bit 4 normal done, bit 6 timer done |

## Verification
A wrong repeat, gap or post-wait counter moves the issue pattern off its expected cycle. Because the bench compares every cycle of every run against a model of the timing, the error shows at the first misplaced issue. A stale or wrongly stepped address or bank register shows on `cmd_addr` or `cmd_bank` no later than the second issue of a stepping slot. A missed reload at a slot or loop boundary shows on that slot's first issue. A stuck state machine or a wrong loop count moves the fall of `status[0]` and the done bit away from the modelled end cycle. A lock that lets config or go writes through changes the rest of that run or the replay that follows it.

// File: rtl/dts_pkg.sv
// Package: shared widths, command and direction encodings, and the slot record
// used by every module of the training command sequencer.
package dts_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SIDX_W    = $clog2(NUM_SLOTS);
    localparam int CNT_W     = 16;
    localparam int GAP_W     = 8;
    localparam int POST_W    = 16;
    localparam int WAIT_W    = (POST_W > GAP_W) ? POST_W : GAP_W;
    localparam int ADDR_W    = 16;
    localparam int BANK_W    = 3;
    localparam int RANK_W    = 2;
    localparam int CMD_W     = 4;
    localparam int WRAP_W    = 5;
    localparam int LOOP_W    = 8;
    localparam int COL_STEP  = 8;
    localparam int DATA_W    = 32;
    // go register field positions
    localparam int GO_SLOT_LSB = 18;
    localparam int GO_TIMER    = 22;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 4'd0, CMD_MRS = 4'd1, CMD_ACT = 4'd2, CMD_RD  = 4'd3,
        CMD_WR  = 4'd4, CMD_PRE = 4'd5, CMD_ZQ  = 4'd6, CMD_NOP2 = 4'd7
    } cmd_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0, DIR_READ = 2'd1, DIR_WRITE = 2'd2
    } dir_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [RANK_W-1:0] rank;
        logic [1:0]        dir;
        logic [CNT_W-1:0]  count;
        logic [GAP_W-1:0]  gap;
        logic [POST_W-1:0] post;
        logic              step_bank;
        logic              step_col;
        logic [WRAP_W-1:0] wrap;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
    } slot_t;
endpackage

// File: rtl/dts_slot_file.sv
// Slot file: holds NUM_SLOTS slot records, written one word at a time.
// Assumes the caller raises `lock` for the whole run; writes are dropped then.
module dts_slot_file
    import dts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [SIDX_W-1:0] wr_slot,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SIDX_W-1:0] rd_slot,
    output slot_t             rd_rec
);
    slot_t table_w [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_t rec_q;
        // Capture the addressed word of this slot when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rec_q <= '0;
            end else if (wr_en && !lock && (wr_slot == SIDX_W'(g))) begin
                case (wr_field)
                    2'd0: begin
                        rec_q.cmd  <= wr_data[3:0];
                        rec_q.rank <= wr_data[5:4];
                        rec_q.dir  <= wr_data[7:6];
                    end
                    2'd1: begin
                        rec_q.count <= wr_data[CNT_W-1:0];
                        rec_q.gap   <= wr_data[16 +: GAP_W];
                    end
                    2'd2: begin
                        rec_q.post      <= wr_data[POST_W-1:0];
                        rec_q.step_bank <= wr_data[16];
                        rec_q.step_col  <= wr_data[17];
                        rec_q.wrap      <= wr_data[18 +: WRAP_W];
                    end
                    default: begin
                        rec_q.addr <= wr_data[ADDR_W-1:0];
                        rec_q.bank <= wr_data[16 +: BANK_W];
                    end
                endcase
            end
        end
        assign table_w[g] = rec_q;
    end

    assign rd_rec = table_w[rd_slot];
endmodule

// File: rtl/dts_addr_step.sv
// Address stepper: next bank and column address after one issue.
// Purely combinational; a wrap position of 0 disables the roll-over.
module dts_addr_step
    import dts_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic              step_bank,
    input  logic              step_col,
    input  logic [WRAP_W-1:0] wrap,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BANK_W-1:0] bank_out
);
    logic [ADDR_W-1:0] sum;

    // Add the column stride and clear bits at or above the wrap position.
    always_comb begin
        sum = addr_in + ADDR_W'(COL_STEP);
        for (int i = 0; i < ADDR_W; i++) begin
            addr_out[i] = step_col ? (sum[i] & ((wrap == '0) || (i < int'(wrap))))
                                   : addr_in[i];
        end
    end

    // Bank advances modulo its natural width.
    assign bank_out = step_bank ? bank_in + BANK_W'(1) : bank_in;
endmodule

// File: rtl/dts_run_ctrl.sv
// Run controller: the issue/gap/post state machine, slot and loop counters,
// busy and done flags. Assumes the slot fields it reads stay stable during a run.
module dts_run_ctrl
    import dts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_we,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [GAP_W-1:0]  cur_gap,
    input  logic [POST_W-1:0] cur_post,
    output logic [SIDX_W-1:0] slot_idx,
    output logic              rep_first,
    output logic              issue,
    output logic              busy,
    output logic              timer_mode,
    output logic              done_norm,
    output logic              done_timer
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GAP, ST_POST} state_e;

    state_e            state_q;
    logic [CNT_W-1:0]  rep_q;
    logic [WAIT_W-1:0] wait_q;
    logic [LOOP_W-1:0] loop_q, loop_last_q;
    logic [SIDX_W-1:0] last_slot_q;
    logic [CNT_W-1:0]  count_eff;
    logic [GAP_W-1:0]  gap_eff;
    logic              last_rep, run_end;
    state_e            adv_state;
    logic [SIDX_W-1:0] adv_slot;
    logic [LOOP_W-1:0] adv_loop;

    // Zero count and zero gap both act as one.
    always_comb begin
        count_eff = (cur_count == '0) ? CNT_W'(1) : cur_count;
        gap_eff   = (cur_gap == '0) ? GAP_W'(1) : cur_gap;
        last_rep  = (rep_q == count_eff - CNT_W'(1));
    end

    // Where the machine goes once a slot (and its post-wait) is finished.
    always_comb begin
        run_end   = (slot_idx == last_slot_q) && (loop_q == loop_last_q);
        adv_state = run_end ? ST_IDLE : ST_ISSUE;
        adv_slot  = (slot_idx == last_slot_q) ? '0 : slot_idx + SIDX_W'(1);
        adv_loop  = (slot_idx == last_slot_q) ? loop_q + LOOP_W'(1) : loop_q;
    end

    // Sequencing state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rep_q       <= '0;
            wait_q      <= '0;
            loop_q      <= '0;
            loop_last_q <= '0;
            last_slot_q <= '0;
            slot_idx    <= '0;
            timer_mode  <= 1'b0;
            done_norm   <= 1'b0;
            done_timer  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go_we) begin
                        state_q     <= ST_ISSUE;
                        rep_q       <= '0;
                        loop_q      <= '0;
                        slot_idx    <= '0;
                        last_slot_q <= go_wdata[GO_SLOT_LSB +: SIDX_W];
                        loop_last_q <= (go_wdata[LOOP_W-1:0] == '0) ? '0
                                       : go_wdata[LOOP_W-1:0] - LOOP_W'(1);
                        timer_mode  <= go_wdata[GO_TIMER];
                        done_norm   <= 1'b0;
                        done_timer  <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (!last_rep) begin
                        rep_q <= rep_q + CNT_W'(1);
                        if (gap_eff > GAP_W'(1)) begin
                            state_q <= ST_GAP;
                            wait_q  <= WAIT_W'(gap_eff) - WAIT_W'(2);
                        end
                    end else begin
                        rep_q <= '0;
                        if (cur_post != '0) begin
                            state_q <= ST_POST;
                            wait_q  <= WAIT_W'(cur_post) - WAIT_W'(1);
                        end else begin
                            state_q  <= adv_state;
                            slot_idx <= adv_slot;
                            loop_q   <= adv_loop;
                            if (run_end) begin
                                done_norm  <= !timer_mode;
                                done_timer <= timer_mode;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (wait_q == '0) state_q <= ST_ISSUE;
                    else              wait_q  <= wait_q - WAIT_W'(1);
                end
                default: begin
                    if (wait_q == '0) begin
                        state_q  <= adv_state;
                        slot_idx <= adv_slot;
                        loop_q   <= adv_loop;
                        if (run_end) begin
                            done_norm  <= !timer_mode;
                            done_timer <= timer_mode;
                        end
                    end else begin
                        wait_q <= wait_q - WAIT_W'(1);
                    end
                end
            endcase
        end
    end

    assign issue     = (state_q == ST_ISSUE);
    assign busy      = (state_q != ST_IDLE);
    assign rep_first = (rep_q == '0);
endmodule

// File: rtl/dts_seq.sv
// Top: training command sequencer. Ties the slot file, run controller and
// address stepper together and drives the command bus and status byte.
// Assumes software writes slots only while idle (writes are dropped otherwise).
module dts_seq
    import dts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_slot,
    input  logic [1:0]        cfg_field,
    input  logic [31:0]       cfg_wdata,
    input  logic              go_we,
    input  logic [31:0]       go_wdata,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic [2:0]        cmd_bank,
    output logic [15:0]       cmd_addr,
    output logic [1:0]        cmd_rank,
    output logic              rd_phase,
    output logic              wr_phase,
    output logic [7:0]        status
);
    slot_t             rec;
    logic [SIDX_W-1:0] slot_idx;
    logic              rep_first, issue, busy, timer_mode, done_norm, done_timer;
    logic [ADDR_W-1:0] run_addr_q, cur_addr, nxt_addr;
    logic [BANK_W-1:0] run_bank_q, cur_bank, nxt_bank;

    dts_slot_file u_slots (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .lock(busy),
        .wr_slot(cfg_slot), .wr_field(cfg_field), .wr_data(cfg_wdata),
        .rd_slot(slot_idx), .rd_rec(rec)
    );

    dts_run_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .go_we(go_we), .go_wdata(go_wdata),
        .cur_count(rec.count), .cur_gap(rec.gap), .cur_post(rec.post),
        .slot_idx(slot_idx), .rep_first(rep_first), .issue(issue), .busy(busy),
        .timer_mode(timer_mode), .done_norm(done_norm), .done_timer(done_timer)
    );

    // First issue of a slot uses the programmed start point.
    assign cur_addr = rep_first ? rec.addr : run_addr_q;
    assign cur_bank = rep_first ? rec.bank : run_bank_q;

    dts_addr_step u_step (
        .addr_in(cur_addr), .bank_in(cur_bank),
        .step_bank(rec.step_bank), .step_col(rec.step_col), .wrap(rec.wrap),
        .addr_out(nxt_addr), .bank_out(nxt_bank)
    );

    // Hold the stepped address and bank for the slot's next issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_addr_q <= '0;
            run_bank_q <= '0;
        end else if (issue) begin
            run_addr_q <= nxt_addr;
            run_bank_q <= nxt_bank;
        end
    end

    // Command bus: fields are driven only on issue cycles outside timer mode.
    always_comb begin
        cmd_valid = issue && !timer_mode;
        cmd_code  = cmd_valid ? rec.cmd  : CMD_NOP;
        cmd_bank  = cmd_valid ? cur_bank : '0;
        cmd_addr  = cmd_valid ? cur_addr : '0;
        cmd_rank  = cmd_valid ? rec.rank : '0;
        rd_phase  = cmd_valid && (rec.dir == DIR_READ);
        wr_phase  = cmd_valid && (rec.dir == DIR_WRITE);
        status    = {1'b0, done_timer, 1'b0, done_norm, 3'b000, busy};
    end
endmodule

// File: rtl/dts_seq_chk.sv
// Checker: port-level properties of the sequencer, bound to every instance.
module dts_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go_we,
    input logic       cmd_valid,
    input logic       rd_phase,
    input logic       wr_phase,
    input logic [7:0] status
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status == 8'h00 && !cmd_valid && !rd_phase && !wr_phase));

    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_we && !status[0]) |=> status[0]);

    assert_cmd_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> status[0]);

    assert_strobe_with_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase || wr_phase) |-> cmd_valid);

    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_phase && wr_phase));

    assert_done_on_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> $countones({status[6], status[4]}) == 1);

    assert_no_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !(status[4] || status[6]));
endmodule

bind dts_seq dts_seq_chk u_dts_seq_chk (
    .clk(clk), .rst_n(rst_n), .go_we(go_we), .cmd_valid(cmd_valid),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .status(status)
);

// File: tb/dts_seq_bench.sv
// Bench: directed corners plus seeded random slot programs, every cycle of each
// run compared against a schedule model built from the requirements.
module dts_seq_bench;
    localparam int MAXC = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0, cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        go_we = 1'b0;
    logic [31:0] go_wdata = '0;
    logic        cmd_valid, rd_phase, wr_phase;
    logic [3:0]  cmd_code;
    logic [2:0]  cmd_bank;
    logic [15:0] cmd_addr;
    logic [1:0]  cmd_rank;
    logic [7:0]  status;

    int n_vec = 0;
    int n_bad = 0;

    // bench copy of the slot program
    int b_cmd[4], b_rank[4], b_dir[4], b_cnt[4], b_gap[4], b_post[4];
    int b_sb[4], b_sc[4], b_wrap[4], b_addr[4], b_bank[4];

    // expected trace, indexed by cycle after the accepting edge
    bit e_v[MAXC];
    int e_cmd[MAXC], e_bank[MAXC], e_addr[MAXC], e_rank[MAXC], e_dir[MAXC];

    always #4 clk = ~clk;  // 125 MHz

    dts_seq u_dts_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .go_we(go_we),
        .go_wdata(go_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_rank(cmd_rank),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .status(status)
    );

    function automatic int step_addr(int a, int w);
        int s = (a + 8) & 16'hFFFF;
        if (w != 0 && w < 16) s = s & ((1 << w) - 1);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int s, input int f, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_field = 2'(f); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_slot(input int s, input int cmd, input int rank, input int dir,
                             input int cnt, input int gap, input int post, input int sb,
                             input int sc, input int wrap, input int addr, input int bank);
        b_cmd[s] = cmd; b_rank[s] = rank; b_dir[s] = dir; b_cnt[s] = cnt;
        b_gap[s] = gap; b_post[s] = post; b_sb[s] = sb; b_sc[s] = sc;
        b_wrap[s] = wrap; b_addr[s] = addr; b_bank[s] = bank;
        cfg_write(s, 0, cmd | (rank << 4) | (dir << 6));
        cfg_write(s, 1, cnt | (gap << 16));
        cfg_write(s, 2, post | (sb << 16) | (sc << 17) | (wrap << 18));
        cfg_write(s, 3, addr | (bank << 16));
    endtask

    // Build the expected schedule; returns the cycle at which busy is low.
    function automatic int model(input int nslots, input int loops, input bit timer);
        int t = 0;
        int nl = (loops == 0) ? 1 : loops;
        for (int i = 0; i < MAXC; i++) e_v[i] = 1'b0;
        for (int l = 0; l < nl; l++) begin
            for (int s = 0; s < nslots; s++) begin
                int a = b_addr[s];
                int b = b_bank[s];
                int c = (b_cnt[s] == 0) ? 1 : b_cnt[s];
                int g = (b_gap[s] == 0) ? 1 : b_gap[s];
                for (int r = 0; r < c; r++) begin
                    if (!timer && t < MAXC) begin
                        e_v[t] = 1'b1; e_cmd[t] = b_cmd[s]; e_rank[t] = b_rank[s];
                        e_dir[t] = b_dir[s]; e_addr[t] = a; e_bank[t] = b;
                    end
                    if (b_sc[s] != 0) a = step_addr(a, b_wrap[s]);
                    if (b_sb[s] != 0) b = (b + 1) % 8;
                    if (r < c - 1) t += g;
                end
                t += b_post[s] + 1;
            end
        end
        return t;
    endfunction

    // Start a run and compare every cycle. `intrude` pokes the go and config
    // ports in cycle 2 of the run (R2, R4).
    task automatic run(input int nslots, input int loops, input bit timer, input bit intrude);
        int end_t = model(nslots, loops, timer);
        @(negedge clk);
        go_we = 1'b1;
        go_wdata = 32'(loops | ((nslots - 1) << 18) | (int'(timer) << 22));
        @(negedge clk);
        go_we = 1'b0;
        for (int k = 0; k <= end_t; k++) begin
            if (k == 0)
                check(status[6:4] == 3'b000, "R11", "done clear on start",
                      int'(status[6:4]), 0);
            if (k < end_t) begin
                check(status[0] == 1'b1, "R3", "busy during run", int'(status[0]), 1);
                check(cmd_valid == e_v[k], timer ? "R12" : "R5", "issue timing",
                      int'(cmd_valid), int'(e_v[k]));
                if (e_v[k] && cmd_valid) begin
                    check(cmd_code == 4'(e_cmd[k]) && cmd_rank == 2'(e_rank[k]),
                          "R13", "code/rank", int'({cmd_code, cmd_rank}),
                          (e_cmd[k] << 2) | e_rank[k]);
                    check(cmd_addr == 16'(e_addr[k]), "R8", "address",
                          int'(cmd_addr), e_addr[k]);
                    check(cmd_bank == 3'(e_bank[k]), "R7", "bank",
                          int'(cmd_bank), e_bank[k]);
                    check(rd_phase == (e_dir[k] == 1) && wr_phase == (e_dir[k] == 2),
                          "R9", "strobes", int'({rd_phase, wr_phase}),
                          ((e_dir[k] == 1) ? 2 : 0) | ((e_dir[k] == 2) ? 1 : 0));
                end
            end else begin
                check(status == (timer ? 8'h40 : 8'h10), "R11", "end status",
                      int'(status), timer ? 32'h40 : 32'h10);
            end
            if (intrude && k == 2) begin
                go_we = 1'b1; go_wdata = 32'h0000_0005;
                cfg_we = 1'b1; cfg_slot = 2'd0; cfg_field = 2'd3; cfg_wdata = 32'h0005_1234;
            end
            if (intrude && k == 3) begin
                go_we = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        check(status[0] == 1'b0, "R4", "stays idle after run", int'(status[0]), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h0D75_5EED);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status == 8'h00 && !cmd_valid && !rd_phase && !wr_phase, "R1",
              "reset outputs", int'({status, cmd_valid, rd_phase, wr_phase}), 0);
        rst_n = 1'b1;

        // R8/R13: column stepping with wrap at bit 8, write direction
        load_slot(0, 4, 1, 2, 4, 4, 3, 0, 1, 8, 16'h00F0, 2);
        run(1, 1, 1'b0, 1'b0);

        // R7/R6: bank stepping wraps 7 -> 0, read slot, post-wait into a second slot
        load_slot(0, 2, 2, 0, 4, 2, 5, 1, 0, 0, 16'h0400, 6);
        load_slot(1, 3, 2, 1, 3, 0, 0, 0, 1, 0, 16'hFFF8, 0);
        run(2, 1, 1'b0, 1'b0);

        // R5/R10: count 0 acts as 1, gap 0, loop count 0 acts as 1, then 3 loops
        load_slot(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0004, 3);
        run(1, 0, 1'b0, 1'b0);
        run(2, 3, 1'b0, 1'b0);

        // R5: long slot, back-to-back issues with stepping
        load_slot(2, 3, 3, 1, 480, 1, 2, 1, 1, 18, 16'h0000, 0);
        load_slot(3, 5, 3, 0, 1, 3, 7, 0, 0, 0, 16'h0400, 0);
        run(4, 1, 1'b0, 1'b0);

        // R12: timer mode keeps the bus quiet with the same schedule
        run(4, 2, 1'b1, 1'b0);

        // R4/R2: go and config writes during a run are ignored; replay proves slot 0 unchanged
        run(2, 2, 1'b0, 1'b1);
        run(2, 1, 1'b0, 1'b0);

        // random programs
        for (int n = 0; n < 25; n++) begin
            int ns = 1 + int'($urandom_range(0, 3));
            for (int s = 0; s < 4; s++)
                load_slot(s, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                          int'($urandom_range(0, 2)), int'($urandom_range(0, 6)),
                          int'($urandom_range(0, 4)), int'($urandom_range(0, 6)),
                          int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                          int'($urandom_range(0, 20)), int'($urandom_range(0, 65535)),
                          int'($urandom_range(0, 7)));
            run(ns, int'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule